// File: doc/BRIEF.md
# Multi-Queue Interrupt Status Unit

This block collects event pulses for a network controller that runs several transmit and receive queues, and turns them into one interrupt line per queue. Every queue owns a status word and a mask word. An event names a queue and carries a word of event bits. Those bits land in that queue's status word only where the queue's mask is clear. A queue's interrupt line is high while its status word is nonzero.

Software never writes a mask directly. Writing an enable register clears mask bits, and writing a disable register sets them. Reading a status word returns it and clears it. Queue 0 is served by a set of main registers. Queues 1 to 15 are served by per-queue banks, and the enable, disable and mask banks each sit in two separate address windows. A read of the main status register also pulls every queue's interrupt line low for one cycle, after which the lines follow their status words again.

The register port is single-cycle and addressed in 32-bit words. Read data is combinational in the request cycle, and the register side effects take place at the clock edge that ends that cycle.

Top module: `iq_unit`

## Requirements
- R1: After synchronous reset every status word is 0, every mask word is all ones, and every interrupt line is low.
- R2: An event for queue q ORs (event bits AND NOT mask) into that queue's status word at the next clock edge. The mask used is the one held before that edge. Masked bits never latch.
- R3: A write to an enable register clears the mask bits that are 1 in the write data. A write to a disable register sets them. Other mask bits are unchanged.
- R4: For a queue n from 1 to 15, using word addresses (byte offset divided by 4): status is at 0x100+(n-1). For n from 1 to 7, enable is at 0x180+(n-1), disable at 0x188+(n-1) and mask at 0x190+(n-1). For n from 8 to 15, enable is at 0x198+(n-8), disable at 0x1A0+(n-8) and mask at 0x1A8+(n-8).
- R5: Queue 0 uses the main registers at word addresses 0x009 (status), 0x00A (enable), 0x00B (disable) and 0x00C (mask).
- R6: A status read returns the word and clears it at the following edge. Writes to status registers are ignored. Mask registers read back their value. Enable and disable registers, and unmapped addresses, read as 0.
- R7: Except in the cycle after a main status read, irq[q] is high exactly when queue q's status word is nonzero. The line changes at the same edge as the status word.
- R8: A read of the main status register forces every interrupt line low for the following cycle. In the cycle after that, each line again follows its status word.
- R9: If an event and a status read hit the same queue in the same cycle, the newly landed bits remain set after the read clears the old contents.
- R10: For queues numbered NUM_Q or higher, registers read as 0, writes have no effect, and events are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | Event pulse strobe |
| evt_queue | input | 4 | Queue index of the event |
| evt_bits | input | DW | Event bits to latch |
| bus_valid | input | 1 | Register access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid in the request cycle |
| irq | output | NUM_Q | One interrupt line per queue |

## Verification
The assertions check, on every cycle, that masked bits never enter a status word and that enable and disable writes move exactly the addressed mask bits. They also check that a read clears a status word unless an event lands in the same cycle, that the lines track nonzero status, that a main status read leaves all lines low for one cycle, and that at most one strobe is decoded per access. The bench scenarios are what show the address map: both windows of each bank, the main registers, and unimplemented queues reading 0 and ignoring writes. They also show that status writes are ignored and that the lines recover in the cycle after the forced drop.

// File: rtl/iq_pkg.sv
package iq_pkg;
    localparam int MAX_Q  = 16;
    localparam int QIDX_W = 4;
    localparam int WADR_W = 10;

    // word addresses of the main (queue 0) registers
    localparam logic [WADR_W-1:0] MAIN_STAT_W = 10'h009;
    localparam logic [WADR_W-1:0] MAIN_EN_W   = 10'h00A;
    localparam logic [WADR_W-1:0] MAIN_DIS_W  = 10'h00B;
    localparam logic [WADR_W-1:0] MAIN_MASK_W = 10'h00C;
    // queue 1..15 banks; lower window covers queues 1..7, upper 8..15
    localparam logic [WADR_W-1:0] QSTAT_W   = 10'h100;
    localparam logic [WADR_W-1:0] QEN_LO_W  = 10'h180;
    localparam logic [WADR_W-1:0] QDIS_LO_W = 10'h188;
    localparam logic [WADR_W-1:0] QMSK_LO_W = 10'h190;
    localparam logic [WADR_W-1:0] QEN_HI_W  = 10'h198;
    localparam logic [WADR_W-1:0] QDIS_HI_W = 10'h1A0;
    localparam logic [WADR_W-1:0] QMSK_HI_W = 10'h1A8;

    typedef enum logic [2:0] {
        RK_NONE, RK_STAT, RK_EN, RK_DIS, RK_MASK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e           kind;
        logic [QIDX_W-1:0]   q;
    } reg_sel_t;

    function automatic logic in_win(input logic [WADR_W-1:0] w,
                                    input logic [WADR_W-1:0] base,
                                    input int unsigned cnt);
        return (w >= base) && (32'(w) < 32'(base) + cnt);
    endfunction

    function automatic reg_sel_t decode_word(input logic [WADR_W-1:0] w);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.q    = '0;
        if (w == MAIN_STAT_W)      s.kind = RK_STAT;
        else if (w == MAIN_EN_W)   s.kind = RK_EN;
        else if (w == MAIN_DIS_W)  s.kind = RK_DIS;
        else if (w == MAIN_MASK_W) s.kind = RK_MASK;
        else if (in_win(w, QSTAT_W, 15)) begin
            s.kind = RK_STAT; s.q = QIDX_W'(w - QSTAT_W + 10'd1);
        end else if (in_win(w, QEN_LO_W, 7)) begin
            s.kind = RK_EN;   s.q = QIDX_W'(w - QEN_LO_W + 10'd1);
        end else if (in_win(w, QDIS_LO_W, 7)) begin
            s.kind = RK_DIS;  s.q = QIDX_W'(w - QDIS_LO_W + 10'd1);
        end else if (in_win(w, QMSK_LO_W, 7)) begin
            s.kind = RK_MASK; s.q = QIDX_W'(w - QMSK_LO_W + 10'd1);
        end else if (in_win(w, QEN_HI_W, 8)) begin
            s.kind = RK_EN;   s.q = QIDX_W'(w - QEN_HI_W + 10'd8);
        end else if (in_win(w, QDIS_HI_W, 8)) begin
            s.kind = RK_DIS;  s.q = QIDX_W'(w - QDIS_HI_W + 10'd8);
        end else if (in_win(w, QMSK_HI_W, 8)) begin
            s.kind = RK_MASK; s.q = QIDX_W'(w - QMSK_HI_W + 10'd8);
        end
        return s;
    endfunction
endpackage

// File: rtl/iq_regdec.sv
module iq_regdec
    import iq_pkg::*;
#(
    parameter int NUM_Q = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [WADR_W-1:0] bus_addr,
    output reg_sel_t          sel,
    output logic              sel_hit,
    output logic              main_rd,
    output logic [NUM_Q-1:0]  rd_stat,
    output logic [NUM_Q-1:0]  wr_en,
    output logic [NUM_Q-1:0]  wr_dis
);
    always_comb begin
        sel     = decode_word(bus_addr);
        sel_hit = bus_valid && (sel.kind != RK_NONE) && (int'(sel.q) < NUM_Q);
        main_rd = sel_hit && !bus_write && (sel.kind == RK_STAT) && (sel.q == '0);
    end

    for (genvar g = 0; g < NUM_Q; g++) begin : g_strobe
        logic mine;
        assign mine       = sel_hit && (sel.q == QIDX_W'(g));
        assign rd_stat[g] = mine && !bus_write && (sel.kind == RK_STAT);
        assign wr_en[g]   = mine &&  bus_write && (sel.kind == RK_EN);
        assign wr_dis[g]  = mine &&  bus_write && (sel.kind == RK_DIS);
    end

    // one access touches at most one register (R4, R5)
    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_stat, wr_en, wr_dis}));
endmodule

// File: rtl/iq_bank.sv
module iq_bank #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          evt_hit,
    input  logic [DW-1:0] evt_bits,
    input  logic          rd_clr,
    input  logic          en_wr,
    input  logic          dis_wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] stat_q,
    output logic [DW-1:0] stat_d,
    output logic [DW-1:0] mask_q
);
    logic [DW-1:0] mask_d;
    logic [DW-1:0] landed;
    logic          past_ok;

    always_comb begin
        landed = evt_hit ? (evt_bits & ~mask_q) : '0;
        stat_d = (rd_clr ? '0 : stat_q) | landed;
        mask_d = mask_q;
        if (en_wr)       mask_d = mask_q & ~wdata;
        else if (dis_wr) mask_d = mask_q | wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q  <= '0;
            mask_q  <= '1;
            past_ok <= 1'b0;
        end else begin
            stat_q  <= stat_d;
            mask_q  <= mask_d;
            past_ok <= 1'b1;
        end
    end

    assert_masked_never_latch_R2: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> ((stat_q & ~$past(stat_q) & $past(mask_q)) == '0));
    assert_enable_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(en_wr)) |-> ((mask_q & $past(wdata)) == '0));
    assert_disable_sets_R3: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(dis_wr)) |-> ((mask_q & $past(wdata)) == $past(wdata)));
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(rd_clr) && !$past(evt_hit)) |-> (stat_q == '0));
    assert_event_wins_R9: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(rd_clr) && $past(evt_hit)) |->
        ((stat_q & $past(evt_bits & ~mask_q)) == $past(evt_bits & ~mask_q)));
endmodule

// File: rtl/iq_unit.sv
module iq_unit
    import iq_pkg::*;
#(
    parameter int NUM_Q = 16,
    parameter int DW    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic [QIDX_W-1:0] evt_queue,
    input  logic [DW-1:0]     evt_bits,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [WADR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [NUM_Q-1:0]  irq
);
    reg_sel_t          sel;
    logic              sel_hit;
    logic              main_rd;
    logic [NUM_Q-1:0]  rd_stat, wr_en, wr_dis;
    logic [DW-1:0]     stat_q [NUM_Q];
    logic [DW-1:0]     stat_d [NUM_Q];
    logic [DW-1:0]     mask_q [NUM_Q];
    logic [NUM_Q-1:0]  nz_now, nz_next;
    logic              past_ok;

    iq_regdec #(.NUM_Q(NUM_Q)) u_dec (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .sel(sel), .sel_hit(sel_hit), .main_rd(main_rd),
        .rd_stat(rd_stat), .wr_en(wr_en), .wr_dis(wr_dis)
    );

    for (genvar g = 0; g < NUM_Q; g++) begin : g_q
        logic hit;
        assign hit = evt_valid && (evt_queue == QIDX_W'(g));
        iq_bank #(.DW(DW)) u_bank (
            .clk(clk), .rst(rst),
            .evt_hit(hit), .evt_bits(evt_bits),
            .rd_clr(rd_stat[g]), .en_wr(wr_en[g]), .dis_wr(wr_dis[g]),
            .wdata(bus_wdata),
            .stat_q(stat_q[g]), .stat_d(stat_d[g]), .mask_q(mask_q[g])
        );
        assign nz_now[g]  = |stat_q[g];
        assign nz_next[g] = |stat_d[g];
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_hit && !bus_write) begin
            for (int i = 0; i < NUM_Q; i++) begin
                if (sel.q == QIDX_W'(i)) begin
                    if (sel.kind == RK_STAT)      bus_rdata = stat_q[i];
                    else if (sel.kind == RK_MASK) bus_rdata = mask_q[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq     <= '0;
            past_ok <= 1'b0;
        end else begin
            irq     <= main_rd ? '0 : nz_next;
            past_ok <= 1'b1;
        end
    end

    assert_irq_drop_after_main_read_R8: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(main_rd)) |-> (irq == '0));
    assert_irq_follows_status_R7: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(main_rd)) |-> (irq == nz_now));
    assert_miss_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !sel_hit) |-> (bus_rdata == '0));
endmodule

// File: tb/test_iq_unit.sv
`timescale 1ns/1ps
module test_iq_unit;
    localparam int NQ = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          evt_valid;
    logic [3:0]    evt_queue;
    logic [DW-1:0] evt_bits;
    logic          bus_valid, bus_write;
    logic [9:0]    bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic [NQ-1:0] irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    iq_unit #(.NUM_Q(NQ), .DW(DW)) i_iq_unit (
        .clk(clk), .rst(rst),
        .evt_valid(evt_valid), .evt_queue(evt_queue), .evt_bits(evt_bits),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // op: 0 write, 1 read+compare, 2 event (addr low bits = queue)
    // layout {op[1:0], req[3:0], addr[9:0], data[31:0], expect[31:0]}
    localparam int NV = 23;
    localparam logic [79:0] VECS [NV] = '{
        {2'd1, 4'd1,  10'h00C, 32'h0,        32'hFFFF_FFFF}, // R1 main mask reset
        {2'd1, 4'd1,  10'h192, 32'h0,        32'hFFFF_FFFF}, // R1 q3 mask reset
        {2'd2, 4'd2,  10'h003, 32'h0000_00F0, 32'h0},        // R2 masked event
        {2'd1, 4'd2,  10'h102, 32'h0,        32'h0},         // R2 nothing latched
        {2'd0, 4'd3,  10'h182, 32'h0000_0030, 32'h0},        // R3 enable q3
        {2'd1, 4'd3,  10'h192, 32'h0,        32'hFFFF_FFCF}, // R3 mask cleared
        {2'd2, 4'd2,  10'h003, 32'h0000_00F0, 32'h0},
        {2'd1, 4'd2,  10'h102, 32'h0,        32'h0000_0030}, // R2 partial latch
        {2'd1, 4'd6,  10'h102, 32'h0,        32'h0},         // R6 read cleared
        {2'd0, 4'd3,  10'h18A, 32'h0000_0010, 32'h0},        // R3 disable q3
        {2'd1, 4'd3,  10'h192, 32'h0,        32'hFFFF_FFDF}, // R3 mask set
        {2'd0, 4'd4,  10'h199, 32'hFFFF_0000, 32'h0},        // R4 upper enable q9
        {2'd1, 4'd4,  10'h1A9, 32'h0,        32'h0000_FFFF}, // R4 upper mask q9
        {2'd2, 4'd4,  10'h009, 32'h1234_5678, 32'h0},
        {2'd1, 4'd4,  10'h108, 32'h0,        32'h1234_0000}, // R4 status q9
        {2'd0, 4'd5,  10'h00A, 32'h0000_0001, 32'h0},        // R5 main enable
        {2'd2, 4'd5,  10'h000, 32'h0000_0003, 32'h0},
        {2'd0, 4'd6,  10'h009, 32'h0000_0000, 32'h0},        // R6 status write ignored
        {2'd1, 4'd5,  10'h009, 32'h0,        32'h0000_0001}, // R5 main status
        {2'd2, 4'd10, 10'h00C, 32'h0000_00FF, 32'h0},        // R10 event q12 ignored
        {2'd0, 4'd10, 10'h19C, 32'hFFFF_FFFF, 32'h0},        // R10 enable q12 ignored
        {2'd1, 4'd10, 10'h1AC, 32'h0,        32'h0},         // R10 q12 mask reads 0
        {2'd1, 4'd6,  10'h182, 32'h0,        32'h0}          // R6 enable reads 0
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic bus_op(input logic wr, input logic [9:0] a, input logic [DW-1:0] d,
                          output logic [DW-1:0] rd);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        #1 rd = bus_rdata;
        @(posedge clk); #0.5;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic fire(input logic [3:0] q, input logic [DW-1:0] b);
        @(negedge clk);
        evt_valid = 1'b1; evt_queue = q; evt_bits = b;
        @(posedge clk); #0.5;
        evt_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired, all requirements: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] rd;
        rst = 1'b1; evt_valid = 1'b0; evt_queue = '0; evt_bits = '0;
        bus_valid = 1'b0; bus_write = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        #0.5 rst = 1'b0;
        @(negedge clk);
        check("R1 irq after reset", DW'(irq), '0);

        for (int v = 0; v < NV; v++) begin
            logic [1:0]  op;
            logic [3:0]  rq;
            logic [9:0]  a;
            logic [31:0] d, e;
            {op, rq, a, d, e} = VECS[v];
            if (op == 2'd2) fire(a[3:0], d);
            else begin
                bus_op(op == 2'd0, a, d, rd);
                if (op == 2'd1) check($sformatf("R%0d vector %0d", rq, v), rd, e);
            end
        end

        // R7: irq rises with status, falls when the read clears it
        bus_op(1'b1, 10'h184, 32'h0000_0003, rd);      // enable q5 bits 1:0
        fire(4'd5, 32'h1);
        @(negedge clk);
        check("R7 irq rises", DW'(irq), DW'(10'b00_0010_0000));
        bus_op(1'b0, 10'h104, '0, rd);
        check("R7 status read value", rd, 32'h1);
        @(negedge clk);
        check("R7 irq falls after clear", DW'(irq), '0);

        // R8: main status read drops all lines for one cycle
        fire(4'd5, 32'h1);
        bus_op(1'b0, 10'h009, '0, rd);
        @(negedge clk);
        check("R8 lines low after main read", DW'(irq), '0);
        @(negedge clk);
        check("R8 lines restored", DW'(irq), DW'(10'b00_0010_0000));

        // R9: event and clearing read in the same cycle on q5
        @(negedge clk);
        evt_valid = 1'b1; evt_queue = 4'd5; evt_bits = 32'h2;
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 10'h104;
        #1 rd = bus_rdata;
        @(posedge clk); #0.5;
        evt_valid = 1'b0; bus_valid = 1'b0;
        check("R9 read sees old", rd, 32'h1);
        bus_op(1'b0, 10'h104, '0, rd);
        check("R9 event survives clear", rd, 32'h2);

        // R10: out-of-range status reads 0
        bus_op(1'b0, 10'h10B, '0, rd);
        check("R10 q12 status", rd, '0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule